// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a processor's register space and the write port of an on-chip flash array, and lets software rewrite flash one page at a time. Software places a command code in a small control register and must then pulse a separate execute strobe within a short window. A command whose strobe comes too late is discarded. This guards against stray writes to flash.

Two commands work on a one-page temporary buffer of 16-bit words. A fill command stores the data word in the buffer slot chosen by the word-select field of a 16-bit pointer. A commit command streams the whole buffer into the flash page chosen by the page-select field, stays busy for a fixed number of cycles, and then reports the address of the first word of the next page. A third command loads the boot-loader lock bits from the data word and takes no notice of the pointer. The low bit of the control register reads as an enable flag. Software polls it to learn that the previous operation has finished.

Top module: `selfprog_ctrl`

## Requirements
- R1: Control code 4'b0001 arms a buffer fill. When it executes, `data_in` is stored in buffer slot `ptr_in[6:1]`, and a later commit writes that slot to flash. A second fill of the same slot overwrites the first.
- R2: Control code 4'b0101 arms a commit. When it executes, the 64 buffer words are written to flash in ascending slot order, one word per cycle, at `flash_addr = {ptr_in[13:7], slot}`. `data_in` has no effect on a commit.
- R3: A command executes only if `exec_stb` is sampled high on the same clock edge as the control write or on one of the following four edges. On a later edge the armed command has already been dropped, and the strobe does nothing.
- R4: Pointer bits 15:14 have no effect on any command. A fill with `ptr_in[0]` = 1 stores nothing and raises `err` for one cycle.
- R5: A commit whose `ptr_in[6:0]` is nonzero writes nothing to flash, leaves `ptr_out` unchanged, clears the enable flag and raises `err` for one cycle.
- R6: When a commit finishes, `ptr_out` becomes the address of word 0 of the following page, `{2'b00, page+1, 7'b0}`, and the page number wraps from 127 to 0.
- R7: `ctl_rdata[0]` reads 1 while a command is armed or a commit is running. A commit keeps it high for exactly BUSY_CYCLES cycles after its execute edge.
- R8: Control code 4'b1001 arms a lock-bit load. When it executes, `lock_we` pulses for one cycle with `lock_wdata = data_in[7:0]`, whatever the pointer holds.
- R9: Control writes and strobes are ignored while a commit is running. During that time `ctl_rdata` reads 4'b0101.
- R10: Every buffer slot holds 16'hFFFF after reset and after each completed commit.
- R11: A control write of any other code disarms the block (`ctl_rdata` reads 0). A strobe with nothing armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 4 | Command code written to the control register |
| ctl_rdata | output | 4 | Control register read; bit 0 is the enable flag |
| exec_stb | input | 1 | Execute strobe |
| ptr_in | input | 16 | Address pointer: page select, word select, byte bit |
| data_in | input | 16 | Data word for fill and lock commands |
| ptr_out | output | 16 | Pointer to the first word of the page after the last commit |
| flash_we | output | 1 | Flash array write enable |
| flash_addr | output | 13 | Flash word address {page, word} |
| flash_wdata | output | 16 | Flash write data |
| lock_we | output | 1 | Lock-bit load pulse |
| lock_wdata | output | 8 | Lock-bit value |
| err | output | 1 | One-cycle pulse on a rejected pointer |

## Verification
A buffer slot written to the wrong place, or not cleared, stays hidden until the next commit. It then shows as a wrong word on `flash_wdata` in that commit's 64-cycle burst. So the bench models the buffer itself and compares every word of every commit. A window counter that is off by one shows within five cycles of a control write, either as the enable flag dropping early or late, or as a strobe at the fourth edge being lost. A busy counter or page register that is wrong shows when the commit ends, in the enable flag's duration and in the value `ptr_out` takes.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
   localparam logic [3:0] CMD_NONE   = 4'b0000;
   localparam logic [3:0] CMD_FILL   = 4'b0001;
   localparam logic [3:0] CMD_COMMIT = 4'b0101;
   localparam logic [3:0] CMD_LOCK   = 4'b1001;

   function automatic logic cmd_known(input logic [3:0] c);
      return (c == CMD_FILL) || (c == CMD_COMMIT) || (c == CMD_LOCK);
   endfunction
endpackage

// File: rtl/selfprog_window.sv
module selfprog_window #(
   parameter int WINDOW = 4,
   parameter int AGE_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       wr_code,
   input  logic             exec,
   output logic             fire,
   output logic [3:0]       fire_code,
   output logic             armed,
   output logic [3:0]       armed_code,
   output logic [AGE_W-1:0] age
);
   import selfprog_pkg::*;

   logic wr_known;
   assign wr_known  = cmd_known(wr_code);
   // a write on the strobe edge counts as cycle zero of its own window
   assign fire      = exec && (wr_en ? wr_known : armed);
   assign fire_code = wr_en ? wr_code : armed_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         armed_code <= CMD_NONE;
         age        <= '0;
      end else if (fire) begin
         armed <= 1'b0;
         age   <= '0;
      end else if (wr_en) begin
         armed      <= wr_known;
         armed_code <= wr_code;
         age        <= '0;
      end else if (armed) begin
         if (age == AGE_W'(WINDOW - 1)) armed <= 1'b0;
         else                           age   <= age + 1'b1;
      end
   end
endmodule

// File: rtl/selfprog_pagebuf.sv
module selfprog_pagebuf #(
   parameter int WS_W   = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WS_W-1:0]   wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear,
   input  logic [WS_W-1:0]   rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PAGE_WORDS = 1 << WS_W;

   logic [DATA_W-1:0] slot_q [PAGE_WORDS];

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '1;
         else if (clear)                            q <= '1;
         else if (wr_en && (wr_idx == WS_W'(i)))    q <= wr_data;
      end
      assign slot_q[i] = q;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/selfprog_commit.sv
module selfprog_commit #(
   parameter int PTR_W       = 16,
   parameter int WS_W        = 6,
   parameter int PS_W        = 7,
   parameter int BUSY_CYCLES = 80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [PS_W-1:0]      page_in,
   output logic                 busy,
   output logic                 flash_we,
   output logic [PS_W+WS_W-1:0] flash_addr,
   output logic [WS_W-1:0]      rd_idx,
   output logic                 clear,
   output logic [PTR_W-1:0]     ptr_out
);
   localparam int PAGE_WORDS = 1 << WS_W;
   localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

   logic [CNT_W-1:0] cnt;
   logic [PS_W-1:0]  page;
   logic [PS_W-1:0]  page_nx;
   logic             last;

   assign last    = busy && (cnt == CNT_W'(BUSY_CYCLES - 1));
   assign page_nx = page + PS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         page    <= '0;
         ptr_out <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         page <= page_in;
      end else if (busy) begin
         if (last) begin
            busy    <= 1'b0;
            ptr_out <= PTR_W'({page_nx, {(WS_W + 1){1'b0}}});
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign flash_we   = busy && (cnt < CNT_W'(PAGE_WORDS));
   assign rd_idx     = cnt[WS_W-1:0];
   assign flash_addr = {page, cnt[WS_W-1:0]};
   assign clear      = last;
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl #(
   parameter int PTR_W       = 16,
   parameter int DATA_W      = 16,
   parameter int WS_W        = 6,
   parameter int PS_W        = 7,
   parameter int WINDOW      = 4,
   parameter int BUSY_CYCLES = 80,
   parameter int LOCK_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [3:0]           ctl_wdata,
   output logic [3:0]           ctl_rdata,
   input  logic                 exec_stb,
   input  logic [PTR_W-1:0]     ptr_in,
   input  logic [DATA_W-1:0]    data_in,
   output logic [PTR_W-1:0]     ptr_out,
   output logic                 flash_we,
   output logic [PS_W+WS_W-1:0] flash_addr,
   output logic [DATA_W-1:0]    flash_wdata,
   output logic                 lock_we,
   output logic [LOCK_W-1:0]    lock_wdata,
   output logic                 err
);
   import selfprog_pkg::*;

   localparam int FA_W       = PS_W + WS_W;
   localparam int PAGE_WORDS = 1 << WS_W;
   localparam int AGE_W      = $clog2(WINDOW + 1);

   if (PTR_W < FA_W + 1) begin : g_bad_ptr
      $error("pointer too narrow for page and word fields");
   end
   if (BUSY_CYCLES < PAGE_WORDS) begin : g_bad_busy
      $error("busy time shorter than one page of writes");
   end
   if (WINDOW < 1) begin : g_bad_window
      $error("execute window must be at least one cycle");
   end
   if (LOCK_W > DATA_W) begin : g_bad_lock
      $error("lock field wider than data word");
   end
   if (PTR_W > FA_W + 1) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^ptr_in[PTR_W-1:FA_W+1];
   end

   logic             busy;
   logic             wr_ok;
   logic             fire;
   logic [3:0]       fire_code;
   logic             armed;
   logic [3:0]       armed_code;
   logic [AGE_W-1:0] age;
   logic             fill_go, commit_go, lock_go;
   logic             fill_bad, commit_bad;
   logic             buf_clear;
   logic [WS_W-1:0]  rd_idx;

   assign wr_ok = ctl_we && !busy;

   selfprog_window #(.WINDOW(WINDOW), .AGE_W(AGE_W)) u_window (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_code(ctl_wdata),
      .exec(exec_stb && !busy), .fire(fire), .fire_code(fire_code),
      .armed(armed), .armed_code(armed_code), .age(age)
   );

   assign fill_go    = fire && (fire_code == CMD_FILL);
   assign commit_go  = fire && (fire_code == CMD_COMMIT);
   assign lock_go    = fire && (fire_code == CMD_LOCK);
   assign fill_bad   = ptr_in[0];
   assign commit_bad = |ptr_in[WS_W:0];

   selfprog_pagebuf #(.WS_W(WS_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_go && !fill_bad), .wr_idx(ptr_in[WS_W:1]), .wr_data(data_in),
      .clear(buf_clear), .rd_idx(rd_idx), .rd_data(flash_wdata)
   );

   selfprog_commit #(.PTR_W(PTR_W), .WS_W(WS_W), .PS_W(PS_W),
                     .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .start(commit_go && !commit_bad),
      .page_in(ptr_in[FA_W:WS_W+1]), .busy(busy), .flash_we(flash_we),
      .flash_addr(flash_addr), .rd_idx(rd_idx), .clear(buf_clear),
      .ptr_out(ptr_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err        <= 1'b0;
         lock_we    <= 1'b0;
         lock_wdata <= '0;
      end else begin
         err     <= (fill_go && fill_bad) || (commit_go && commit_bad);
         lock_we <= lock_go;
         if (lock_go) lock_wdata <= data_in[LOCK_W-1:0];
      end
   end

   assign ctl_rdata = busy  ? CMD_COMMIT :
                      armed ? armed_code : CMD_NONE;
endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
   parameter int FA_W   = 13,
   parameter int WINDOW = 4,
   parameter int AGE_W  = 3,
   parameter int PTR_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flash_we,
   input logic [FA_W-1:0]  flash_addr,
   input logic [3:0]       ctl_rdata,
   input logic [PTR_W-1:0] ptr_out,
   input logic             err,
   input logic             lock_we,
   input logic             busy,
   input logic             armed,
   input logic [AGE_W-1:0] age
);
   // R2: consecutive flash writes walk up one word at a time
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      flash_we && $past(flash_we) |-> flash_addr == $past(flash_addr) + FA_W'(1));

   // R7: flash is written only while the enable flag reads high
   a_r7_write_enable: assert property (@(posedge clk) disable iff (!rst_n)
      flash_we |-> ctl_rdata[0]);

   // R6: the pointer output moves only as a commit ends
   a_r6_ptr_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr_out) |-> $past(busy) && !busy);

   // R5: a rejected pointer never coincides with a commit in progress
   a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !flash_we);

   // R8: lock load, flash write and error are mutually exclusive
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock_we, flash_we, err}));

   // R9: the control read value holds steady through a commit
   a_r9_busy_steady: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(ctl_rdata));

   // R3: an armed command never outlives its window
   a_r3_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> age < AGE_W'(WINDOW));

   // R3: at the last window cycle the arm is dropped or restarted
   a_r3_expire: assert property (@(posedge clk) disable iff (!rst_n)
      armed && age == AGE_W'(WINDOW - 1) |=> !armed || age == '0);
endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(
   .FA_W(FA_W), .WINDOW(WINDOW), .AGE_W(AGE_W), .PTR_W(PTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flash_we(flash_we), .flash_addr(flash_addr),
   .ctl_rdata(ctl_rdata), .ptr_out(ptr_out), .err(err), .lock_we(lock_we),
   .busy(busy), .armed(armed), .age(age)
);

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;
   localparam int BUSY = 80;
   localparam logic [3:0] C_FILL   = 4'b0001;
   localparam logic [3:0] C_COMMIT = 4'b0101;
   localparam logic [3:0] C_LOCK   = 4'b1001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [3:0]  ctl_wdata = '0;
   logic [3:0]  ctl_rdata;
   logic        exec_stb = 1'b0;
   logic [15:0] ptr_in = '0;
   logic [15:0] data_in = '0;
   logic [15:0] ptr_out;
   logic        flash_we;
   logic [12:0] flash_addr;
   logic [15:0] flash_wdata;
   logic        lock_we;
   logic [7:0]  lock_wdata;
   logic        err;

   always #5 clk = ~clk;

   selfprog_ctrl #(.BUSY_CYCLES(BUSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .exec_stb(exec_stb), .ptr_in(ptr_in),
      .data_in(data_in), .ptr_out(ptr_out), .flash_we(flash_we),
      .flash_addr(flash_addr), .flash_wdata(flash_wdata), .lock_we(lock_we),
      .lock_wdata(lock_wdata), .err(err)
   );

   int tests = 0;
   int fails = 0;

   // fill vectors: pointer, data, strobe delay, expected to store
   localparam int VN = 8;
   localparam logic [15:0] V_PTR [VN] = '{16'h0000, 16'h0002, 16'h0004, 16'hC07E,
                                          16'h0009, 16'h0002, 16'h3F8A, 16'h0010};
   localparam logic [15:0] V_DAT [VN] = '{16'hA001, 16'hA002, 16'hA003, 16'hA03F,
                                          16'hA004, 16'hB002, 16'hC005, 16'hD008};
   localparam int          V_DLY [VN] = '{0, 4, 5, 3, 2, 2, 1, 7};
   localparam bit          V_OK  [VN] = '{1'b1, 1'b1, 1'b0, 1'b1,
                                          1'b0, 1'b1, 1'b1, 1'b0};

   logic [15:0] model [64];
   logic [15:0] seen  [64];
   int          fl_cnt = 0;
   int          fl_order_bad = 0;
   logic [6:0]  fl_page = '0;
   int          lock_cnt = 0;
   logic [7:0]  lock_last = '0;
   int          err_cnt = 0;

   always @(negedge clk) begin
      if (flash_we) begin
         if (int'(flash_addr[5:0]) != (fl_cnt % 64)) fl_order_bad++;
         seen[flash_addr[5:0]] = flash_wdata;
         fl_page = flash_addr[12:6];
         fl_cnt++;
      end
      if (lock_we) begin
         lock_cnt++;
         lock_last = lock_wdata;
      end
      if (err) err_cnt++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic issue(input logic [3:0] code, input logic [15:0] p,
                        input logic [15:0] d, input int dly);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = code; ptr_in = p; data_in = d;
      exec_stb = (dly == 0);
      @(negedge clk);
      ctl_we = 1'b0; exec_stb = 1'b0;
      if (dly > 0) begin
         repeat (dly - 1) @(negedge clk);
         exec_stb = 1'b1;
         @(negedge clk);
         exec_stb = 1'b0;
      end
   endtask

   // commit with strobe on the write edge; returns busy length
   task automatic commit(input logic [15:0] p, output int n);
      issue(C_COMMIT, p, 16'h1357, 0);
      n = 0;
      while (ctl_rdata[0] && n < 1000) begin
         n++;
         @(negedge clk);
      end
      #1;
   endtask

   task automatic check_page(input string req, input logic [6:0] pg);
      chk(fl_cnt == 64, req, "flash write count", fl_cnt, 64);
      chk(fl_order_bad == 0, req, "ascending order", fl_order_bad, 0);
      chk(fl_page == pg, req, "flash page", fl_page, pg);
      for (int k = 0; k < 64; k++)
         if (seen[k] !== model[k])
            chk(1'b0, req, $sformatf("word %0d", k), seen[k], model[k]);
      chk(1'b1, req, "page contents", 0, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n;
      int e0;
      int l0;
      for (int k = 0; k < 64; k++) model[k] = 16'hFFFF;
      repeat (3) @(negedge clk);
      chk(ctl_rdata == 4'h0, "R7", "reset control read", ctl_rdata, 0);
      chk(ptr_out == 16'h0, "R6", "reset pointer", ptr_out, 0);
      chk(!flash_we && !err && !lock_we, "R10", "reset outputs idle",
          {flash_we, err, lock_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R7: enable flag while armed, dropped after four edges
      ctl_we = 1'b1; ctl_wdata = C_FILL;
      @(negedge clk);
      ctl_we = 1'b0;
      chk(ctl_rdata == C_FILL, "R7", "armed read", ctl_rdata, C_FILL);
      repeat (3) @(negedge clk);
      chk(ctl_rdata == C_FILL, "R3", "armed at fourth edge", ctl_rdata, C_FILL);
      @(negedge clk);
      chk(ctl_rdata == 4'h0, "R3", "window expired", ctl_rdata, 0);

      // R1/R3/R4: fill vector table
      for (int i = 0; i < VN; i++) begin
         settle();
         e0 = err_cnt;
         issue(C_FILL, V_PTR[i], V_DAT[i], V_DLY[i]);
         settle();
         if (V_OK[i]) model[V_PTR[i][6:1]] = V_DAT[i];
         chk((err_cnt - e0) == ((V_PTR[i][0] && V_DLY[i] <= 4) ? 1 : 0), "R4",
             $sformatf("fill %0d error pulses", i), err_cnt - e0,
             (V_PTR[i][0] && V_DLY[i] <= 4) ? 1 : 0);
         chk(ctl_rdata == 4'h0, "R7", $sformatf("fill %0d idle after", i),
             ctl_rdata, 0);
      end

      // R1/R2/R6/R7: commit to page 53
      fl_cnt = 0; fl_order_bad = 0;
      commit(16'h1A80, n);
      chk(n == BUSY, "R7", "busy duration", n, BUSY);
      check_page("R1", 7'd53);
      chk(ptr_out == 16'h1B00, "R6", "next page pointer", ptr_out, 16'h1B00);
      for (int k = 0; k < 64; k++) model[k] = 16'hFFFF;

      // R5: misaligned commits are rejected
      settle();
      fl_cnt = 0; e0 = err_cnt;
      issue(C_COMMIT, 16'h0081, 16'h0, 1);
      settle();
      chk(ctl_rdata == 4'h0, "R5", "enable cleared on abort", ctl_rdata, 0);
      issue(C_COMMIT, 16'h00C0, 16'h0, 0);
      settle();
      chk(err_cnt - e0 == 2, "R5", "abort error pulses", err_cnt - e0, 2);
      chk(fl_cnt == 0, "R5", "no flash writes", fl_cnt, 0);
      chk(ptr_out == 16'h1B00, "R5", "pointer unchanged", ptr_out, 16'h1B00);

      // R10/R4/R6: buffer cleared, page 127 wraps, bits 15:14 ignored
      fl_cnt = 0; fl_order_bad = 0;
      commit(16'hFF80, n);
      check_page("R10", 7'd127);
      chk(ptr_out == 16'h0000, "R6", "pointer wraps", ptr_out, 0);

      // R8: lock load ignores pointer
      settle();
      l0 = lock_cnt;
      issue(C_LOCK, 16'h1234, 16'h77A5, 3);
      settle();
      chk(lock_cnt - l0 == 1 && lock_last == 8'hA5, "R8", "lock load",
          lock_last, 8'hA5);
      issue(C_LOCK, 16'hFFFF, 16'h005A, 0);
      settle();
      chk(lock_cnt - l0 == 2 && lock_last == 8'h5A, "R8", "lock odd pointer",
          lock_last, 8'h5A);

      // R9: writes during a commit are ignored
      fl_cnt = 0;
      issue(C_COMMIT, 16'h0100, 16'h0, 0);
      l0 = lock_cnt; e0 = err_cnt;
      issue(C_LOCK, 16'h0000, 16'h00EE, 0);
      issue(C_FILL, 16'h0001, 16'h0, 1);
      #1;
      chk(ctl_rdata == C_COMMIT, "R9", "busy read", ctl_rdata, C_COMMIT);
      n = 0;
      while (ctl_rdata[0] && n < 1000) begin
         n++;
         @(negedge clk);
      end
      settle();
      chk(lock_cnt == l0, "R9", "lock ignored while busy", lock_cnt, l0);
      chk(err_cnt == e0, "R9", "fill ignored while busy", err_cnt - e0, 0);
      chk(ptr_out == 16'h0180, "R9", "busy commit completes", ptr_out, 16'h0180);

      // R11: unknown code and bare strobe do nothing
      l0 = lock_cnt; e0 = err_cnt; fl_cnt = 0;
      issue(4'b0011, 16'h0000, 16'h0, 0);
      settle();
      chk(ctl_rdata == 4'h0, "R11", "unknown code not armed", ctl_rdata, 0);
      ctl_we = 1'b1; ctl_wdata = C_LOCK;
      @(negedge clk);
      ctl_wdata = 4'b0110;
      @(negedge clk);
      ctl_we = 1'b0; exec_stb = 1'b1;
      @(negedge clk);
      exec_stb = 1'b0;
      settle();
      chk(lock_cnt == l0 && err_cnt == e0 && fl_cnt == 0, "R11",
          "disarmed strobe inert", lock_cnt - l0, 0);
      chk(ctl_rdata == 4'h0, "R11", "idle after bare strobe", ctl_rdata, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule